// File: doc/BRIEF.md
# Reference-Cycle and Seconds Timebase

This block is a free-running timebase driven by a fixed reference clock (25 MHz by default). It keeps two read-only 32-bit counters. The sub-second counter counts reference cycles in coarse steps of 16 and returns to zero once per second. The seconds counter counts how many times the sub-second counter has wrapped since the last cold reset.

Software reads the counters through a small request/response port: one request per cycle with a valid, a write flag and a word index, and a registered response one cycle later. Neither counter can be written. A write aimed at the sub-second counter is refused and flagged with an error pulse. A write aimed at the seconds counter is silently dropped. The wrap point and the step size are parameters, so a bench can shrink the one-second period.

Top module: `tbase_counters`

## Requirements
- R1: After a synchronous active-high reset (`rst`), both counters read zero, the internal divide-by-16 phase restarts, and `rsp_valid` and `rsp_err` are low.
- R2: Bits [3:0] of the sub-second counter always read zero.
- R3: The sub-second counter changes only once every 16 clock cycles, and each change adds exactly 16. After m clock cycles out of reset it holds 16*floor(m/16) modulo WRAP.
- R4: The sub-second counter never reaches WRAP (default 25,000,000). At the update that would reach WRAP it returns to zero instead.
- R5: The seconds counter rises by one in the same clock edge as the sub-second counter wraps, and it holds its value at every other edge. A read never pairs a wrapped sub-second value with a stale seconds value.
- R6: A write to word 1 (the sub-second counter) leaves the counter unchanged. It produces a response with `rsp_err` high for exactly one cycle and `rsp_rdata` zero.
- R7: A write to word 0 (the seconds counter) leaves that counter unchanged and responds with `rsp_err` low.
- R8: A read of word 0 returns the seconds counter and a read of word 1 returns the sub-second counter. A read of words 2 or 3 returns zero with `rsp_err` low.
- R9: `rsp_valid` is high in exactly the cycle after each cycle in which `req_valid` is high. The returned data is the counter value as it stood before the clock edge that accepted the request.
- R10: Asserting `rst` while the counters are running clears them. Counting then resumes from zero with a new 16-cycle phase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; every edge is one reference cycle |
| rst | input | 1 | Synchronous active-high cold reset |
| req_valid | input | 1 | Request strobe, one access per cycle |
| req_write | input | 1 | 1 = write attempt, 0 = read |
| req_word | input | 2 | Word index: 0 seconds, 1 sub-second, 2-3 unmapped |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data; zero for writes and unmapped words |
| rsp_err | output | 1 | One-cycle pulse for a refused write to the sub-second counter |

## Verification
The bench uses a short wrap period. This lets it read at the cycles just before and just after several wraps. A design that wraps one step late, or that bumps the seconds count one cycle after the wrap, returns a mismatched pair at that boundary. Each read is compared with a cycle-exact model counted from reset. A prescaler that is off by one or that is not cleared by reset therefore shows up as a value 16 counts off, and a low nibble that is not zero shows up directly. The bench writes to both counters and then reads them back to catch a write that leaks into state. It also checks that the error is a single-cycle pulse that appears only for the sub-second word.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
  localparam int WORD_W = 2;

  typedef enum logic [WORD_W-1:0] {
    WORD_SECONDS = 2'd0,
    WORD_SUBSEC  = 2'd1,
    WORD_SPARE2  = 2'd2,
    WORD_SPARE3  = 2'd3
  } word_e;
endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale #(
  parameter int STEP_LOG2 = 4
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  logic [STEP_LOG2-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) phase_q <= '0;
    else     phase_q <= phase_q + 1'b1;
  end

  // Last cycle of each group of 2**STEP_LOG2 cycles enables one update.
  assign tick = &phase_q;
endmodule

// File: rtl/tbase_subsec.sv
module tbase_subsec #(
  parameter int DATA_W    = 32,
  parameter int STEP_LOG2 = 4,
  parameter int WRAP      = 25_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  output logic [DATA_W-1:0] value,
  output logic              wrap
);
  localparam int STEP = 1 << STEP_LOG2;
  localparam logic [DATA_W-1:0] LAST = DATA_W'(WRAP - STEP);

  logic [DATA_W-1:0] count_q;

  assign wrap = tick && (count_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (wrap) count_q <= '0;
    else if (tick) count_q <= count_q + DATA_W'(STEP);
  end

  assign value = count_q;
endmodule

// File: rtl/tbase_seconds.sv
module tbase_seconds #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inc,
  output logic [DATA_W-1:0] value
);
  logic [DATA_W-1:0] count_q;

  always_ff @(posedge clk) begin
    if (rst)      count_q <= '0;
    else if (inc) count_q <= count_q + 1'b1;
  end

  assign value = count_q;
endmodule

// File: rtl/tbase_regif.sv
module tbase_regif
  import tbase_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_word,
  input  logic [DATA_W-1:0] sec_val,
  input  logic [DATA_W-1:0] sub_val,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic [DATA_W-1:0] rd_mux;
  logic              refuse;

  always_comb begin
    rd_mux = '0;
    if (!req_write) begin
      case (word_e'(req_word))
        WORD_SECONDS: rd_mux = sec_val;
        WORD_SUBSEC:  rd_mux = sub_val;
        default:      rd_mux = '0;
      endcase
    end
  end

  assign refuse = req_valid && req_write && (word_e'(req_word) == WORD_SUBSEC);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= req_valid ? rd_mux : '0;
      rsp_err   <= refuse;
    end
  end
endmodule

// File: rtl/tbase_counters.sv
module tbase_counters
  import tbase_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int STEP_LOG2 = 4,
  parameter int WRAP      = 25_000_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [WORD_W-1:0] req_word,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  logic              tick_w;
  logic              wrap_w;
  logic [DATA_W-1:0] sub_w;
  logic [DATA_W-1:0] sec_w;

  tbase_prescale #(.STEP_LOG2(STEP_LOG2)) u_pre (
    .clk(clk), .rst(rst), .tick(tick_w)
  );

  tbase_subsec #(.DATA_W(DATA_W), .STEP_LOG2(STEP_LOG2), .WRAP(WRAP)) u_sub (
    .clk(clk), .rst(rst), .tick(tick_w), .value(sub_w), .wrap(wrap_w)
  );

  tbase_seconds #(.DATA_W(DATA_W)) u_sec (
    .clk(clk), .rst(rst), .inc(wrap_w), .value(sec_w)
  );

  tbase_regif #(.DATA_W(DATA_W)) u_rif (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
    .sec_val(sec_w), .sub_val(sub_w),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err)
  );
endmodule

// File: rtl/tbase_counters_chk.sv
module tbase_counters_chk #(
  parameter int DATA_W    = 32,
  parameter int STEP_LOG2 = 4,
  parameter int WRAP      = 25_000_000
) (
  input logic              clk,
  input logic              rst,
  input logic              tick,
  input logic [DATA_W-1:0] sub,
  input logic [DATA_W-1:0] sec,
  input logic              req_valid,
  input logic              req_write,
  input logic [1:0]        req_word,
  input logic              rsp_valid,
  input logic              rsp_err
);
  localparam int STEP = 1 << STEP_LOG2;

  assert_low_zero_R2: assert property (@(posedge clk) disable iff (rst)
    sub[STEP_LOG2-1:0] == '0);

  assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(sub));

  assert_step_R3: assert property (@(posedge clk) disable iff (rst)
    (tick && sub != DATA_W'(WRAP - STEP)) |=> sub == $past(sub) + DATA_W'(STEP));

  assert_below_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    sub < DATA_W'(WRAP));

  assert_wrap_zero_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && sub == DATA_W'(WRAP - STEP)) |=> sub == '0);

  assert_sec_inc_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && sub == DATA_W'(WRAP - STEP)) |=> sec == $past(sec) + 1'b1);

  assert_sec_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !(tick && sub == DATA_W'(WRAP - STEP)) |=> $stable(sec));

  assert_err_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && req_word == 2'd1) |=> rsp_err);

  assert_err_only_R7: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write && req_word == 2'd1) |=> !rsp_err);

  assert_rsp_follow_R9: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  assert_rsp_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);
endmodule

bind tbase_counters tbase_counters_chk #(
  .DATA_W(DATA_W), .STEP_LOG2(STEP_LOG2), .WRAP(WRAP)
) chk_i (
  .clk(clk), .rst(rst), .tick(tick_w), .sub(sub_w), .sec(sec_w),
  .req_valid(req_valid), .req_write(req_write), .req_word(req_word),
  .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/tbase_counters_tb.sv
module tbase_counters_tb_top;
  localparam int DW   = 32;
  localparam int WRAP = 320;
  localparam int STEP = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [1:0]    req_word = 2'd0;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_err;

  int    n_checks = 0;
  int    n_fail   = 0;
  longint n = 0;

  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (rst) n <= 0;
    else     n <= n + 1;
  end

  tbase_counters #(.DATA_W(DW), .STEP_LOG2(4), .WRAP(WRAP)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_word(req_word), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_err(rsp_err)
  );

  function automatic longint exp_sub(longint m);
    return ((m / STEP) * STEP) % WRAP;
  endfunction

  function automatic longint exp_sec(longint m);
    return ((m / STEP) * STEP) / WRAP;
  endfunction

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input logic [1:0] word,
                        output logic [DW-1:0] data, output bit err,
                        output bit vld, output longint m);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_word = word; m = n;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
    data = rsp_rdata; err = rsp_err; vld = rsp_valid;
  endtask

  task automatic wait_until(input longint target);
    while (n < target - 1) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic read_both(input string tag);
    logic [DW-1:0] d; bit e, v; longint m;
    access(1'b0, 2'd1, d, e, v, m);
    check(d == exp_sub(m), {tag, " R3 subsec"}, d, exp_sub(m));
    check(d[3:0] == 4'd0, {tag, " R2 low nibble"}, d[3:0], 0);
    check(d < WRAP, {tag, " R4 below wrap"}, d, WRAP);
    access(1'b0, 2'd0, d, e, v, m);
    check(d == exp_sec(m), {tag, " R5 seconds"}, d, exp_sec(m));
  endtask

  task automatic t_reset_state();
    logic [DW-1:0] d; bit e, v; longint m;
    check(rsp_valid == 1'b0 && rsp_err == 1'b0, "R1 idle outputs", {rsp_valid, rsp_err}, 0);
    access(1'b0, 2'd1, d, e, v, m);
    check(d == 0 && m < STEP, "R1 subsec after reset", d, 0);
    access(1'b0, 2'd0, d, e, v, m);
    check(d == 0, "R1 seconds after reset", d, 0);
  endtask

  task automatic t_stepping();
    for (int k = 0; k < 6; k++) begin
      wait_until(40 + k * 7);
      read_both("step");
    end
  endtask

  task automatic t_wrap();
    for (int s = 1; s <= 3; s++) begin
      wait_until(s * WRAP - 2);
      read_both("pre-wrap");
      read_both("post-wrap");
    end
  endtask

  task automatic t_write_subsec();
    logic [DW-1:0] d; bit e, v; longint m;
    access(1'b1, 2'd1, d, e, v, m);
    check(e == 1'b1 && v == 1'b1, "R6 error on subsec write", e, 1);
    check(d == 0, "R6 write response data", d, 0);
    @(negedge clk);
    check(rsp_err == 1'b0, "R6 error one cycle", rsp_err, 0);
    check(rsp_valid == 1'b0, "R9 valid one cycle", rsp_valid, 0);
    access(1'b0, 2'd1, d, e, v, m);
    check(d == exp_sub(m), "R6 subsec unchanged by write", d, exp_sub(m));
  endtask

  task automatic t_write_seconds();
    logic [DW-1:0] d; bit e, v; longint m;
    access(1'b1, 2'd0, d, e, v, m);
    check(e == 1'b0 && v == 1'b1, "R7 no error on seconds write", e, 0);
    access(1'b0, 2'd0, d, e, v, m);
    check(d == exp_sec(m), "R7 seconds unchanged by write", d, exp_sec(m));
  endtask

  task automatic t_unmapped();
    logic [DW-1:0] d; bit e, v; longint m;
    for (int w = 2; w < 4; w++) begin
      access(1'b0, 2'(w), d, e, v, m);
      check(d == 0 && !e, "R8 unmapped word reads zero", d, 0);
      check(v == 1'b1, "R9 response valid", v, 1);
    end
  endtask

  task automatic t_midrun_reset();
    wait_until(WRAP * 3 + 100);
    do_reset();
    t_reset_state();
    wait_until(17);
    read_both("R10 after reset");
  endtask

  initial begin
    bit done = 1'b0;
    fork
      begin
        do_reset();
        t_reset_state();
        t_stepping();
        t_write_subsec();
        t_write_seconds();
        t_unmapped();
        t_wrap();
        t_midrun_reset();
        done = 1'b1;
      end
      begin
        repeat (20000) @(negedge clk);
      end
    join_any
    disable fork;
    if (!done) check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule